// File: doc/BRIEF.md
# Clock-Enable Converter for Gated and Derived Clocks

This block lets logic that was once clocked by several gated or derived clocks run from one fast, free-running clock. Each derived clock comes in as a plain data signal. The block samples it on the fast clock and turns every rising edge into an enable pulse that lasts one fast cycle. Registers in that domain then load only when their enable is high.

Gating of the simple kind, where a gate forces the clock low when it is 0 and lets the base clock through when it is 1, takes a shorter path. The gate level is registered on the fast clock and used directly as an enable. Gating that cannot hold the clock off, such as an exclusive-or, cannot take this path. Neither can a selection between two clocks. The combined clock from either must be brought in on an edge-detect input instead.

One counter per domain shows how the enables are used. Each counter is an enabled register on the fast clock. It steps once for every active period of its original clock.

Top module: `clken_converter`

## Requirements
- R1: Every register in the block is clocked by `clk` alone, and reset is asynchronous and active low. While `rst_n` is low, all enables and all counters read 0.
- R2: Suppose a derived-clock input is 0 at one rising edge of `clk` and 1 at the next. The matching `edge_en` bit is then 1 for exactly the one `clk` cycle that follows the second edge.
- R3: A derived-clock input that stays at one level for any number of fast cycles raises no enable. The number of `edge_en` pulses equals the number of 0-to-1 changes seen on the input.
- R4: At the first `clk` edge after reset is released, the detector loads its current input as both the newer and the older sample. An input that is already high when reset is released therefore raises no pulse until it falls and rises again.
- R5: Each `gate_en` bit equals its `gate_in` bit as sampled at the previous rising edge of `clk`. It changes only at `clk` edges.
- R6: Each demo counter is `CNT_W` bits wide. It adds 1, wrapping modulo 2^CNT_W, at the `clk` edge that ends a cycle in which its enable is 1. Otherwise it holds its value.
- R7: Domain i's derived counter sits in bits [i*CNT_W +: CNT_W] of `edge_cnt`. One cycle after the last enable, it equals the count of rising edges of derived input i since reset release, modulo 2^CNT_W. Domain j's gated counter sits in bits [j*CNT_W +: CNT_W] of `gate_cnt`.
- R8: Domains are independent. Edges or gate levels on one input never change the enable or counter of another domain, even when several inputs change in the same cycle.
- R9: The edge path works when the fast clock runs at least twice as fast as the derived clock, that is, when each high and low phase lasts at least one fast cycle. A derived clock that toggles every fast cycle gives one pulse every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk_in | input | N_EDGE | Derived or non-convertible clocks, sampled as data |
| gate_in | input | N_GATE | Gate levels of AND-style clock gates |
| edge_en | output | N_EDGE | One-cycle enable per rising edge of each derived clock |
| gate_en | output | N_GATE | Registered gate level used as an enable |
| edge_cnt | output | N_EDGE*CNT_W | Demo counters of the derived domains, packed |
| gate_cnt | output | N_GATE*CNT_W | Demo counters of the gated domains, packed |

## Verification
The derived inputs are driven with random phase lengths of one to four fast cycles. This shows that each rise gives exactly one pulse with the stated latency, whatever the duty cycle. A stretch in which every input toggles on every cycle tests the minimum supported rate. A slow stretch, with phases of up to a dozen cycles, separates a level from an edge. Inputs held high across reset release, both before the first run and at a second reset mid-run, show whether the arming step stops a false pulse. Each counter is compared with a bench counter clocked by the original derived signal, and each gate enable with the delayed gate level. A long random run carries the counters past their wrap point.

// File: rtl/clken_pkg.sv
package clken_pkg;
  parameter int unsigned DEF_N_EDGE = 3;
  parameter int unsigned DEF_N_GATE = 2;
  parameter int unsigned DEF_CNT_W  = 8;

  // newer / older samples of a derived clock taken on the fast clock
  typedef struct packed {
    logic newer;
    logic older;
  } samp_pair_t;
endpackage

// File: rtl/clken_edge_det.sv
module clken_edge_det
  import clken_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic en
);
  samp_pair_t sp;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp   <= '0;
      live <= 1'b0;
    end else begin
      sp.newer <= din;
      sp.older <= live ? sp.newer : din;
      live     <= 1'b1;
    end
  end

  assign en = live & sp.newer & ~sp.older;

  // R2
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !en);
  // R3
  pulse_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $past(din));
endmodule

// File: rtl/clken_gate_conv.sv
module clken_gate_conv (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic en
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign en = gate_q;

  // R5
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> en == $past(gate));
endmodule

// File: rtl/clken_demo_reg.sv
module clken_demo_reg #(
  parameter int unsigned CNT_W = clken_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q + 1'b1;
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q == CNT_W'($past(q) + 1'b1));
endmodule

// File: rtl/clken_converter.sv
module clken_converter #(
  parameter int unsigned N_EDGE = clken_pkg::DEF_N_EDGE,
  parameter int unsigned N_GATE = clken_pkg::DEF_N_GATE,
  parameter int unsigned CNT_W  = clken_pkg::DEF_CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_EDGE-1:0]       dclk_in,
  input  logic [N_GATE-1:0]       gate_in,
  output logic [N_EDGE-1:0]       edge_en,
  output logic [N_GATE-1:0]       gate_en,
  output logic [N_EDGE*CNT_W-1:0] edge_cnt,
  output logic [N_GATE*CNT_W-1:0] gate_cnt
);
  localparam int unsigned EDGE_BITS = N_EDGE * CNT_W;
  localparam int unsigned GATE_BITS = N_GATE * CNT_W;

  logic [EDGE_BITS-1:0] edge_q;
  logic [GATE_BITS-1:0] gate_q;

  for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
    clken_edge_det u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (dclk_in[i]),
      .en    (edge_en[i])
    );
    clken_demo_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (edge_en[i]),
      .q     (edge_q[i*CNT_W +: CNT_W])
    );
  end

  for (genvar j = 0; j < N_GATE; j++) begin : g_gate
    clken_gate_conv u_conv (
      .clk   (clk),
      .rst_n (rst_n),
      .gate  (gate_in[j]),
      .en    (gate_en[j])
    );
    clken_demo_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (gate_en[j]),
      .q     (gate_q[j*CNT_W +: CNT_W])
    );
  end

  assign edge_cnt = edge_q;
  assign gate_cnt = gate_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (edge_en == '0 && gate_en == '0 && edge_cnt == '0 && gate_cnt == '0));
endmodule

// File: tb/test_clken_converter.sv
module test_clken_converter;
  localparam int NE = 3;
  localparam int NG = 2;
  localparam int W  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NE-1:0]   dclk_in = '0;
  logic [NG-1:0]   gate_in = '0;
  logic [NE-1:0]   edge_en;
  logic [NG-1:0]   gate_en;
  logic [NE*W-1:0] edge_cnt;
  logic [NG*W-1:0] gate_cnt;

  int n_cmp = 0;
  int n_bad = 0;

  clken_converter #(.N_EDGE(NE), .N_GATE(NG), .CNT_W(W)) i_clken_converter (
    .clk(clk), .rst_n(rst_n), .dclk_in(dclk_in), .gate_in(gate_in),
    .edge_en(edge_en), .gate_en(gate_en), .edge_cnt(edge_cnt), .gate_cnt(gate_cnt)
  );

  always #5 clk = ~clk;

  // reference counters clocked by the original derived clocks (R7)
  int ref_cnt [NE];
  int ref_base[NE];
  for (genvar i = 0; i < NE; i++) begin : g_ref
    initial ref_cnt[i] = 0;
    always @(posedge dclk_in[i]) ref_cnt[i] = ref_cnt[i] + 1;
  end

  logic [NE-1:0] prv_d;
  int            hold[NE];
  int            gsum[NG];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_edge_cnt(input int i, input logic pend);
    return (ref_cnt[i] - ref_base[i] - int'(pend)) % (1 << W);
  endfunction

  // sample outputs and compare, then commit history
  task automatic sample(input string tag);
    for (int i = 0; i < NE; i++) begin
      logic pend;
      pend = dclk_in[i] & ~prv_d[i];
      chk({tag, " R2/R3 edge_en"}, int'(edge_en[i]), int'(pend));
      chk({tag, " R7 edge_cnt"}, int'(edge_cnt[i*W +: W]), exp_edge_cnt(i, pend));
    end
    for (int j = 0; j < NG; j++) begin
      chk({tag, " R5 gate_en"}, int'(gate_en[j]), int'(gate_in[j]));
      chk({tag, " R6 gate_cnt"}, int'(gate_cnt[j*W +: W]), gsum[j] % (1 << W));
      gsum[j] += int'(gate_in[j]);
    end
    prv_d = dclk_in;
  endtask

  task automatic do_reset(input logic [NE-1:0] dval, input logic [NG-1:0] gval);
    rst_n   = 1'b0;
    dclk_in = dval;
    gate_in = gval;
    repeat (3) @(negedge clk);
    chk("R1 reset edge_en", int'(edge_en), 0);
    chk("R1 reset gate_en", int'(gate_en), 0);
    chk("R1 reset edge_cnt", int'(edge_cnt), 0);
    chk("R1 reset gate_cnt", int'(gate_cnt), 0);
    rst_n = 1'b1;
    prv_d = dclk_in;  // R4: first sample loads both stages
    for (int i = 0; i < NE; i++) ref_base[i] = ref_cnt[i];
    for (int j = 0; j < NG; j++) gsum[j] = 0;
  endtask

  // mode 0: random phases 1..4, 1: toggle each cycle, 2: slow 5..12
  task automatic run(input int cycles, input int mode, input string tag);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      sample(tag);
      for (int i = 0; i < NE; i++) begin
        if (mode == 1) dclk_in[i] = ~dclk_in[i];
        else if (hold[i] <= 1) begin
          dclk_in[i] = ~dclk_in[i];
          hold[i] = (mode == 2) ? int'($urandom_range(12, 5)) : int'($urandom_range(4, 1));
        end else hold[i]--;
      end
      for (int j = 0; j < NG; j++) gate_in[j] = logic'($urandom_range(1, 0));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c10c));
    for (int i = 0; i < NE; i++) hold[i] = 1;
    // R4: domain 0 held high through reset release
    do_reset(3'b001, 2'b11);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4 held-high no pulse", int'(edge_en[0]), 0);
      sample("R4");
    end
    @(negedge clk); sample("R4"); dclk_in[0] = 1'b0;
    @(negedge clk); sample("R4"); dclk_in[0] = 1'b1;
    @(negedge clk); sample("R4"); // expects pulse on domain 0
    // R8: all domains rise together, then one alone
    dclk_in = '0; gate_in = 2'b01;
    @(negedge clk); sample("R8");
    dclk_in = 3'b111; gate_in = 2'b10;
    @(negedge clk); sample("R8");
    dclk_in = 3'b010;
    @(negedge clk); sample("R8");
    dclk_in = 3'b011;
    @(negedge clk); sample("R8");
    @(negedge clk); sample("R8");
    // R9: fastest supported derived rate
    run(40, 1, "R9 fast");
    // long random run wraps the counters (R6)
    run(3000, 0, "R3 random");
    run(400, 2, "R3 slow");
    // second reset with levels high (R1, R4)
    do_reset(3'b110, 2'b01);
    run(20, 2, "R4 after reset");
    run(500, 0, "R7 random");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule